// File: doc/BRIEF.md
# Near-Memory Load/Store Pairing Buffer

This buffer sits inside a processing unit on the memory side of a system and lets offloaded code perform loads and stores with no address translation of its own. The processor resolves every address before anything reaches this unit. For a load, the processor issues a forwarded read, and the memory returns the data into the buffer tagged for a particular instruction. The local load instruction then reads that tagged entry instead of accessing memory. For a store, the processor sends only the physical write address. The local computation supplies the data. The buffer pairs the two halves by tag and sends each complete pair to the memory controller as one write request.

Every arrival carries a tag made of an offload instance number and a sequence index. A local load whose data is not present yet stalls, and it completes in the same cycle the data arrives. The two halves of a store may arrive in either order, or in the same cycle. Writes of one instance leave in store-ordinal order. The buffer tracks outstanding writes for each instance. When the local side declares an instance finished, the buffer signals completion only once every write of that instance has been acknowledged.

Top module: `nm_pair_buffer`

## Requirements
- R1: After reset, `wr_valid` and `done_valid` are 0, `in_ready` is 1, and a local load with no matching entry sees `ex_ready` 0.
- R2: A network arrival with `in_is_addr`=0 (load data) is held in an entry. A later local load (`ex_is_store`=0) with the same instance and sequence tag completes with that data and frees the entry.
- R3: A local load whose tagged data is absent stalls with `ex_ready` 0. In the cycle the matching load data is accepted at the network input, `ex_ready` is 1 and `ex_rdata` equals `in_data`. No entry is kept for that data.
- R4: A store address (`in_is_addr`=1) and local store data (`ex_is_store`=1) with equal tags produce exactly one write request carrying that address, data, instance and sequence, whichever half arrived first.
- R5: When both halves of a store arrive in the same cycle, both are accepted in that cycle and yield a single write request.
- R6: For each instance, store sequence indices count from 0. Write requests of an instance leave in increasing sequence order, and a complete pair waits until all lower-numbered pairs of its instance have left.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, the write request stays valid and its address, data, instance and sequence do not change.
- R8: When every entry is occupied, `in_ready` is 0 for load data. Once a local load consumes an entry, the refused arrival is accepted.
- R9: `done_valid` pulses for one cycle with `done_inst` only after `end_valid` has named that instance and every local store of it has been acknowledged on `wack_valid`/`wack_inst`. The instance's store sequence numbering then restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Network arrival valid |
| in_ready | output | 1 | Network arrival accepted when high with in_valid |
| in_is_addr | input | 1 | 1: store physical address, 0: load data |
| in_inst | input | INST_W | Offload instance of the arrival |
| in_seq | input | SEQ_W | Sequence index of the arrival |
| in_addr | input | ADDR_W | Physical write address |
| in_data | input | DATA_W | Load data returned from memory |
| ex_valid | input | 1 | Local load/store request |
| ex_ready | output | 1 | Local request completes this cycle |
| ex_is_store | input | 1 | 1: store data, 0: load |
| ex_inst | input | INST_W | Instance tag of local request |
| ex_seq | input | SEQ_W | Sequence tag of local request |
| ex_wdata | input | DATA_W | Store data from the local datapath |
| ex_rdata | output | DATA_W | Load result |
| wr_valid | output | 1 | Write request to the memory controller |
| wr_ready | input | 1 | Memory controller accepts the write |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_inst | output | INST_W | Instance of the write |
| wr_seq | output | SEQ_W | Sequence index of the write |
| wack_valid | input | 1 | Write acknowledgment |
| wack_inst | input | INST_W | Instance of the acknowledged write |
| end_valid | input | 1 | Local side finished an instance |
| end_inst | input | INST_W | Instance that finished |
| done_valid | output | 1 | Instance completion pulse |
| done_inst | output | INST_W | Completed instance |

## Verification
The hardest situations to reach from the ports are the same-cycle coincidences: a stalled load meeting its data in the arrival cycle, and both store halves landing on one edge. The bench drives the network and local ports together on a single falling edge and samples the handshakes before the next rising edge. Sequence ordering is forced by completing higher-numbered pairs first and confirming that nothing leaves. A full buffer is reached by parking load data in every entry and holding one more arrival against the backpressure. Random phases shuffle the order of address and data halves across instances while `wr_ready` toggles at random.

// File: rtl/nmpb_pkg.sv
package nmpb_pkg;

    typedef enum logic {
        SLOT_LOAD  = 1'b0,
        SLOT_STORE = 1'b1
    } nmpb_kind_e;

    typedef struct packed {
        logic       live;
        nmpb_kind_e kind;
        logic       has_addr;
        logic       has_data;
    } nmpb_flags_t;

    localparam nmpb_flags_t FLAGS_EMPTY = '{live: 1'b0, kind: SLOT_LOAD,
                                            has_addr: 1'b0, has_data: 1'b0};

    function automatic logic [1:0] cnt_step(input logic inc, input logic dec);
        return {inc & ~dec, dec & ~inc};
    endfunction

endpackage

// File: rtl/nmpb_first_set.sv
module nmpb_first_set #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/nmpb_inst_track.sv
module nmpb_inst_track
    import nmpb_pkg::*;
#(
    parameter int INST_W = 4,
    parameter int SEQ_W  = 8,
    parameter int CNT_W  = 10,
    localparam int NUM_INST = 1 << INST_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           st_acc,
    input  logic [INST_W-1:0]              st_inst,
    input  logic                           wack_valid,
    input  logic [INST_W-1:0]              wack_inst,
    input  logic                           wr_acc,
    input  logic [INST_W-1:0]              wr_inst,
    input  logic                           end_valid,
    input  logic [INST_W-1:0]              end_inst,
    output logic [NUM_INST-1:0][SEQ_W-1:0] next_seq,
    output logic                           done_valid,
    output logic [INST_W-1:0]              done_inst
);
    logic [NUM_INST-1:0]            ended;
    logic [NUM_INST-1:0][CNT_W-1:0] pending;
    logic [NUM_INST-1:0]            quiet;

    always_comb begin
        for (int i = 0; i < NUM_INST; i++) begin
            quiet[i] = ended[i] && (pending[i] == '0);
        end
    end

    nmpb_first_set #(.N(NUM_INST)) u_done_pick (
        .vec   (quiet),
        .found (done_valid),
        .idx   (done_inst)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ended    <= '0;
            pending  <= '0;
            next_seq <= '0;
        end else begin
            for (int i = 0; i < NUM_INST; i++) begin
                logic [1:0] step;
                step = cnt_step(st_acc && (st_inst == INST_W'(i)),
                                wack_valid && (wack_inst == INST_W'(i)));
                if (step[1])      pending[i] <= pending[i] + 1'b1;
                else if (step[0]) pending[i] <= pending[i] - 1'b1;

                if (wr_acc && (wr_inst == INST_W'(i)))
                    next_seq[i] <= next_seq[i] + 1'b1;
                if (end_valid && (end_inst == INST_W'(i)))
                    ended[i] <= 1'b1;
                if (done_valid && (done_inst == INST_W'(i))) begin
                    ended[i]    <= 1'b0;
                    next_seq[i] <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/nm_pair_buffer.sv
module nm_pair_buffer
    import nmpb_pkg::*;
#(
    parameter int ENTRIES = 512,
    parameter int DATA_W  = 1024,
    parameter int ADDR_W  = 48,
    parameter int INST_W  = 4,
    parameter int SEQ_W   = 8,
    parameter int CNT_W   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_is_addr,
    input  logic [INST_W-1:0] in_inst,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              ex_valid,
    output logic              ex_ready,
    input  logic              ex_is_store,
    input  logic [INST_W-1:0] ex_inst,
    input  logic [SEQ_W-1:0]  ex_seq,
    input  logic [DATA_W-1:0] ex_wdata,
    output logic [DATA_W-1:0] ex_rdata,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [INST_W-1:0] wr_inst,
    output logic [SEQ_W-1:0]  wr_seq,
    input  logic              wack_valid,
    input  logic [INST_W-1:0] wack_inst,
    input  logic              end_valid,
    input  logic [INST_W-1:0] end_inst,
    output logic              done_valid,
    output logic [INST_W-1:0] done_inst
);
    localparam int IDX_W    = $clog2(ENTRIES);
    localparam int NUM_INST = 1 << INST_W;

    nmpb_flags_t       fl     [ENTRIES];
    logic [INST_W-1:0] e_inst [ENTRIES];
    logic [SEQ_W-1:0]  e_seq  [ENTRIES];
    logic [ADDR_W-1:0] e_addr [ENTRIES];
    logic [DATA_W-1:0] e_data [ENTRIES];

    logic [NUM_INST-1:0][SEQ_W-1:0] next_seq;

    logic [ENTRIES-1:0] free_vec, free2_vec, netf_vec, exf_vec, exl_vec, elig_vec;
    logic               free1_found, free2_found, netf_found, exf_found, exl_found, elig_found;
    logic [IDX_W-1:0]   free1_idx, free2_idx, netf_idx, exf_idx, exl_idx, elig_idx;

    // tag comparison against every entry
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            logic in_tag, ex_tag;
            in_tag = (e_inst[i] == in_inst) && (e_seq[i] == in_seq);
            ex_tag = (e_inst[i] == ex_inst) && (e_seq[i] == ex_seq);
            free_vec[i] = !fl[i].live;
            netf_vec[i] = fl[i].live && (fl[i].kind == SLOT_STORE) && fl[i].has_data
                          && !fl[i].has_addr && in_tag;
            exf_vec[i]  = fl[i].live && (fl[i].kind == SLOT_STORE) && fl[i].has_addr
                          && !fl[i].has_data && ex_tag;
            exl_vec[i]  = fl[i].live && (fl[i].kind == SLOT_LOAD) && ex_tag;
            elig_vec[i] = fl[i].live && (fl[i].kind == SLOT_STORE) && fl[i].has_addr
                          && fl[i].has_data && (e_seq[i] == next_seq[e_inst[i]]);
        end
    end

    assign free2_vec = free_vec & ~({{(ENTRIES-1){1'b0}}, 1'b1} << free1_idx);

    nmpb_first_set #(.N(ENTRIES)) u_free1 (.vec(free_vec),  .found(free1_found), .idx(free1_idx));
    nmpb_first_set #(.N(ENTRIES)) u_free2 (.vec(free2_vec), .found(free2_found), .idx(free2_idx));
    nmpb_first_set #(.N(ENTRIES)) u_netf  (.vec(netf_vec),  .found(netf_found),  .idx(netf_idx));
    nmpb_first_set #(.N(ENTRIES)) u_exf   (.vec(exf_vec),   .found(exf_found),   .idx(exf_idx));
    nmpb_first_set #(.N(ENTRIES)) u_exl   (.vec(exl_vec),   .found(exl_found),   .idx(exl_idx));
    nmpb_first_set #(.N(ENTRIES)) u_elig  (.vec(elig_vec),  .found(elig_found),  .idx(elig_idx));

    // arrival / local-request resolution
    logic             net_acc, net_fill, net_alloc, same_tag, bypass, merge;
    logic             ex_ld, ex_st, ex_acc, ex_fill, ex_alloc, ex_slot_ok;
    logic [IDX_W-1:0] ex_slot;

    always_comb begin
        in_ready   = free1_found || (in_is_addr && netf_found);
        net_acc    = in_valid && in_ready;
        net_fill   = net_acc && in_is_addr && netf_found;
        ex_ld      = ex_valid && !ex_is_store;
        ex_st      = ex_valid && ex_is_store;
        same_tag   = (in_inst == ex_inst) && (in_seq == ex_seq);
        bypass     = net_acc && !in_is_addr && ex_ld && !exl_found && same_tag;
        merge      = net_acc && in_is_addr && !netf_found && ex_st && !exf_found && same_tag;
        net_alloc  = net_acc && !bypass && !net_fill;
        ex_slot_ok = net_alloc ? free2_found : free1_found;
        ex_slot    = net_alloc ? free2_idx : free1_idx;
        if (ex_ld)      ex_ready = exl_found || bypass;
        else if (ex_st) ex_ready = exf_found || merge || ex_slot_ok;
        else            ex_ready = 1'b0;
        ex_acc     = ex_valid && ex_ready;
        ex_fill    = ex_st && ex_acc && exf_found;
        ex_alloc   = ex_st && ex_acc && !exf_found && !merge;
        ex_rdata   = exl_found ? e_data[exl_idx] : in_data;
    end

    // write-request issue with a locked selection under backpressure
    logic             hold_v, wr_acc;
    logic [IDX_W-1:0] hold_idx, sel_idx;

    always_comb begin
        sel_idx  = hold_v ? hold_idx : elig_idx;
        wr_valid = hold_v || elig_found;
        wr_addr  = e_addr[sel_idx];
        wr_data  = e_data[sel_idx];
        wr_inst  = e_inst[sel_idx];
        wr_seq   = e_seq[sel_idx];
        wr_acc   = wr_valid && wr_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) fl[i] <= FLAGS_EMPTY;
            hold_v   <= 1'b0;
            hold_idx <= '0;
        end else begin
            if (wr_acc) begin
                fl[sel_idx].live <= 1'b0;
                hold_v           <= 1'b0;
            end else if (wr_valid) begin
                hold_v   <= 1'b1;
                hold_idx <= sel_idx;
            end
            if (ex_ld && exl_found) fl[exl_idx].live <= 1'b0;
            if (net_fill)           fl[netf_idx].has_addr <= 1'b1;
            if (ex_fill)            fl[exf_idx].has_data <= 1'b1;
            if (net_alloc)
                fl[free1_idx] <= '{live: 1'b1,
                                   kind: in_is_addr ? SLOT_STORE : SLOT_LOAD,
                                   has_addr: in_is_addr,
                                   has_data: !in_is_addr || merge};
            if (ex_alloc)
                fl[ex_slot] <= '{live: 1'b1, kind: SLOT_STORE,
                                 has_addr: 1'b0, has_data: 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (net_fill) e_addr[netf_idx] <= in_addr;
        if (ex_fill)  e_data[exf_idx]  <= ex_wdata;
        if (net_alloc) begin
            e_inst[free1_idx] <= in_inst;
            e_seq[free1_idx]  <= in_seq;
            e_addr[free1_idx] <= in_addr;
            e_data[free1_idx] <= merge ? ex_wdata : in_data;
        end
        if (ex_alloc) begin
            e_inst[ex_slot] <= ex_inst;
            e_seq[ex_slot]  <= ex_seq;
            e_data[ex_slot] <= ex_wdata;
        end
    end

    nmpb_inst_track #(.INST_W(INST_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .st_acc     (ex_st && ex_acc),
        .st_inst    (ex_inst),
        .wack_valid (wack_valid),
        .wack_inst  (wack_inst),
        .wr_acc     (wr_acc),
        .wr_inst    (wr_inst),
        .end_valid  (end_valid),
        .end_inst   (end_inst),
        .next_seq   (next_seq),
        .done_valid (done_valid),
        .done_inst  (done_inst)
    );
endmodule

// File: rtl/nm_pair_buffer_chk.sv
module nm_pair_buffer_chk #(
    parameter int ENTRIES = 512,
    parameter int DATA_W  = 1024,
    parameter int ADDR_W  = 48,
    parameter int INST_W  = 4,
    parameter int SEQ_W   = 8,
    parameter int CNT_W   = 10,
    localparam int NUM_INST = 1 << INST_W
) (
    input logic               clk,
    input logic               rst,
    input logic [ENTRIES-1:0] free_vec,
    input logic               in_valid,
    input logic               in_ready,
    input logic               in_is_addr,
    input logic [INST_W-1:0]  in_inst,
    input logic [SEQ_W-1:0]   in_seq,
    input logic [DATA_W-1:0]  in_data,
    input logic               ex_valid,
    input logic               ex_ready,
    input logic               ex_is_store,
    input logic [INST_W-1:0]  ex_inst,
    input logic [SEQ_W-1:0]   ex_seq,
    input logic [DATA_W-1:0]  ex_rdata,
    input logic               wr_valid,
    input logic               wr_ready,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic [INST_W-1:0]  wr_inst,
    input logic [SEQ_W-1:0]   wr_seq,
    input logic               wack_valid,
    input logic [INST_W-1:0]  wack_inst,
    input logic               done_valid,
    input logic [INST_W-1:0]  done_inst
);
    logic [SEQ_W-1:0] want_seq [NUM_INST];
    logic [CNT_W-1:0] in_flight [NUM_INST];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_INST; i++) begin
                want_seq[i]  <= '0;
                in_flight[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_INST; i++) begin
                logic up, down;
                up   = wr_valid && wr_ready && (wr_inst == INST_W'(i));
                down = wack_valid && (wack_inst == INST_W'(i));
                if (up && !down)      in_flight[i] <= in_flight[i] + 1'b1;
                else if (down && !up) in_flight[i] <= in_flight[i] - 1'b1;
                if (done_valid && (done_inst == INST_W'(i))) want_seq[i] <= '0;
                else if (up)                                  want_seq[i] <= want_seq[i] + 1'b1;
            end
        end
    end

    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (&free_vec) |-> !wr_valid);

    assert_bypass_data_R3: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && !ex_is_store && in_valid && in_ready && !in_is_addr
         && ex_inst == in_inst && ex_seq == in_seq) |-> (ex_ready && ex_rdata == in_data));

    assert_seq_order_R6: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_seq == want_seq[wr_inst]));

    assert_wr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)
                                     && $stable(wr_inst) && $stable(wr_seq)));

    assert_full_refuse_R8: assert property (@(posedge clk) disable iff (rst)
        (free_vec == '0 && in_valid && !in_is_addr) |-> !in_ready);

    assert_done_acked_R9: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (in_flight[done_inst] == '0));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !(done_valid && done_inst == $past(done_inst)));
endmodule

bind nm_pair_buffer nm_pair_buffer_chk #(
    .ENTRIES(ENTRIES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .INST_W(INST_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .free_vec(free_vec),
    .in_valid(in_valid), .in_ready(in_ready), .in_is_addr(in_is_addr),
    .in_inst(in_inst), .in_seq(in_seq), .in_data(in_data),
    .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_is_store(ex_is_store),
    .ex_inst(ex_inst), .ex_seq(ex_seq), .ex_rdata(ex_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_inst(wr_inst), .wr_seq(wr_seq),
    .wack_valid(wack_valid), .wack_inst(wack_inst),
    .done_valid(done_valid), .done_inst(done_inst)
);

// File: tb/nm_pair_buffer_test.sv
module nm_pair_buffer_test;
    localparam int ENT = 8, DW = 32, AW = 16, IW = 2, SW = 4, CW = 6;

    logic clk = 0, rst = 1;
    always #2.5 clk = ~clk;

    logic in_valid = 0, in_is_addr = 0, ex_valid = 0, ex_is_store = 0;
    logic wr_ready = 1, wack_valid = 0, end_valid = 0;
    logic [IW-1:0] in_inst = 0, ex_inst = 0, wack_inst = 0, end_inst = 0;
    logic [SW-1:0] in_seq = 0, ex_seq = 0;
    logic [AW-1:0] in_addr = 0;
    logic [DW-1:0] in_data = 0, ex_wdata = 0;
    logic in_ready, ex_ready, wr_valid, done_valid;
    logic [DW-1:0] ex_rdata, wr_data;
    logic [AW-1:0] wr_addr;
    logic [IW-1:0] wr_inst, done_inst;
    logic [SW-1:0] wr_seq;

    nm_pair_buffer #(.ENTRIES(ENT), .DATA_W(DW), .ADDR_W(AW), .INST_W(IW),
                     .SEQ_W(SW), .CNT_W(CW)) uut (.*);

    int n_tests = 0, n_fail = 0;
    bit auto_ack = 1, wr_rand = 0, wr_force_low = 0;
    logic [AW-1:0] cap_addr[$];
    logic [DW-1:0] cap_data[$];
    logic [IW-1:0] cap_inst[$];
    logic [SW-1:0] cap_seq[$];
    logic [IW-1:0] ack_q[$];
    bit done_seen [4];

    function automatic logic [AW-1:0] xa(int inst, int seq);
        return AW'(16'h4000 + inst * 16'h0400 + seq * 16'h0008);
    endfunction
    function automatic logic [DW-1:0] xd(int inst, int seq);
        return 32'h5A00_0000 | DW'(inst << 12) | DW'(seq << 4) | 32'h3;
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst && wr_valid && wr_ready) begin
            cap_addr.push_back(wr_addr); cap_data.push_back(wr_data);
            cap_inst.push_back(wr_inst); cap_seq.push_back(wr_seq);
            ack_q.push_back(wr_inst);
        end
        if (!rst && done_valid) done_seen[done_inst] = 1;
    end

    always @(negedge clk) begin
        wr_ready = wr_force_low ? 1'b0 : (wr_rand ? 1'($urandom % 2) : 1'b1);
        if (auto_ack) begin
            if (ack_q.size() > 0) begin wack_valid = 1; wack_inst = ack_q.pop_front(); end
            else wack_valid = 0;
        end
    end

    task automatic clear_caps();
        cap_addr.delete(); cap_data.delete(); cap_inst.delete(); cap_seq.delete();
    endtask

    task automatic net_send(bit a, int inst, int seq, logic [AW-1:0] ad, logic [DW-1:0] d);
        @(negedge clk);
        in_valid = 1; in_is_addr = a; in_inst = IW'(inst); in_seq = SW'(seq);
        in_addr = ad; in_data = d;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1; in_valid = 0;
    endtask

    task automatic ex_send(bit st, int inst, int seq, logic [DW-1:0] wd, output logic [DW-1:0] rd);
        @(negedge clk);
        ex_valid = 1; ex_is_store = st; ex_inst = IW'(inst); ex_seq = SW'(seq); ex_wdata = wd;
        #1;
        while (!ex_ready) begin @(negedge clk); #1; end
        rd = ex_rdata;
        @(posedge clk); #1; ex_valid = 0;
    endtask

    task automatic wait_caps(int n);
        for (int k = 0; k < 60 && cap_addr.size() < n; k++) @(negedge clk);
    endtask

    task automatic finish_inst(int inst, output bit seen);
        done_seen[inst] = 0;
        @(negedge clk); end_valid = 1; end_inst = IW'(inst);
        @(posedge clk); #1; end_valid = 0;
        for (int k = 0; k < 400 && !done_seen[inst]; k++) @(negedge clk);
        seen = done_seen[inst];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        logic [AW-1:0] ha;
        logic [DW-1:0] hd;
        bit seen;
        int unsigned sd;
        sd = $urandom(32'd7741);
        repeat (4) @(posedge clk);
        #1 rst = 0;

        // R1: reset state
        @(negedge clk);
        ex_valid = 1; ex_is_store = 0; ex_inst = 0; ex_seq = 5; #1;
        check("R1", "wr_valid", wr_valid, 0);
        check("R1", "done_valid", done_valid, 0);
        check("R1", "in_ready", in_ready, 1);
        check("R1", "ex_ready", ex_ready, 0);
        @(posedge clk); #1 ex_valid = 0;

        // R2: load data parked then consumed
        net_send(0, 1, 3, '0, 32'hCAFE_0103);
        ex_send(0, 1, 3, '0, rd);
        check("R2", "load data", rd, 32'hCAFE_0103);
        @(negedge clk); ex_valid = 1; ex_is_store = 0; ex_inst = 1; ex_seq = 3; #1;
        check("R2", "entry freed", ex_ready, 0);
        @(posedge clk); #1 ex_valid = 0;

        // R3: stall then same-cycle arrival
        @(negedge clk); ex_valid = 1; ex_is_store = 0; ex_inst = 2; ex_seq = 9; #1;
        check("R3", "stall", ex_ready, 0);
        @(negedge clk); #1;
        check("R3", "still stalled", ex_ready, 0);
        @(negedge clk);
        in_valid = 1; in_is_addr = 0; in_inst = 2; in_seq = 9; in_data = 32'hBEEF_0209; #1;
        check("R3", "complete on arrival", ex_ready, 1);
        check("R3", "bypass data", ex_rdata, 32'hBEEF_0209);
        @(posedge clk); #1; in_valid = 0;
        @(negedge clk); #1;
        check("R3", "no entry kept", ex_ready, 0);
        @(posedge clk); #1 ex_valid = 0;

        // R4: address first, then data
        clear_caps();
        net_send(1, 0, 0, xa(0, 0), '0);
        ex_send(1, 0, 0, xd(0, 0), rd);
        wait_caps(1); repeat (3) @(negedge clk);
        check("R4", "addr-first count", cap_addr.size(), 1);
        check("R4", "addr-first addr", cap_addr[0], xa(0, 0));
        check("R4", "addr-first data", cap_data[0], xd(0, 0));
        finish_inst(0, seen);
        check("R9", "inst0 done", seen, 1);

        // R4/R9: data first after restart of numbering
        clear_caps();
        ex_send(1, 0, 0, xd(0, 7), rd);
        @(negedge clk); @(negedge clk); #1;
        check("R4", "data alone no write", wr_valid, 0);
        net_send(1, 0, 0, xa(0, 7), '0);
        wait_caps(1); repeat (3) @(negedge clk);
        check("R4", "data-first count", cap_addr.size(), 1);
        check("R4", "data-first addr", cap_addr[0], xa(0, 7));
        check("R4", "data-first data", cap_data[0], xd(0, 7));
        check("R9", "seq restart", cap_seq[0], 0);
        finish_inst(0, seen);

        // R5: both halves in the same cycle
        clear_caps();
        @(negedge clk);
        in_valid = 1; in_is_addr = 1; in_inst = 3; in_seq = 0; in_addr = xa(3, 0);
        ex_valid = 1; ex_is_store = 1; ex_inst = 3; ex_seq = 0; ex_wdata = xd(3, 0); #1;
        check("R5", "in_ready", in_ready, 1);
        check("R5", "ex_ready", ex_ready, 1);
        @(posedge clk); #1; in_valid = 0; ex_valid = 0;
        wait_caps(1); repeat (4) @(negedge clk);
        check("R5", "single write", cap_addr.size(), 1);
        check("R5", "merged data", cap_data[0], xd(3, 0));
        check("R5", "merged addr", cap_addr[0], xa(3, 0));
        finish_inst(3, seen);

        // R6: higher ordinals complete first
        clear_caps();
        net_send(1, 1, 2, xa(1, 2), '0); ex_send(1, 1, 2, xd(1, 2), rd);
        net_send(1, 1, 1, xa(1, 1), '0); ex_send(1, 1, 1, xd(1, 1), rd);
        repeat (3) @(negedge clk); #1;
        check("R6", "later pairs wait", wr_valid, 0);
        ex_send(1, 1, 0, xd(1, 0), rd); net_send(1, 1, 0, xa(1, 0), '0);
        wait_caps(3); repeat (2) @(negedge clk);
        check("R6", "count", cap_addr.size(), 3);
        for (int k = 0; k < 3; k++) begin
            check("R6", "order seq", cap_seq[k], k);
            check("R6", "order data", cap_data[k], xd(1, k));
        end
        finish_inst(1, seen);

        // R7: backpressure holds the request
        clear_caps();
        wr_force_low = 1;
        net_send(1, 0, 0, xa(0, 4), '0); ex_send(1, 0, 0, xd(0, 4), rd);
        @(negedge clk); #1;
        check("R7", "valid under stall", wr_valid, 1);
        ha = wr_addr; hd = wr_data;
        repeat (3) @(negedge clk);
        #1;
        check("R7", "valid held", wr_valid, 1);
        check("R7", "addr held", wr_addr, ha);
        check("R7", "data held", wr_data, hd);
        wr_force_low = 0;
        wait_caps(1); repeat (3) @(negedge clk);
        check("R7", "one write after release", cap_addr.size(), 1);
        finish_inst(0, seen);

        // R8: fill every entry with load data
        for (int k = 0; k < ENT; k++) net_send(0, 3, k, '0, xd(3, k));
        @(negedge clk);
        in_valid = 1; in_is_addr = 0; in_inst = 3; in_seq = 8; in_data = xd(3, 8); #1;
        check("R8", "refused when full", in_ready, 0);
        @(negedge clk); #1;
        check("R8", "still refused", in_ready, 0);
        ex_valid = 1; ex_is_store = 0; ex_inst = 3; ex_seq = 0; #1;
        check("R8", "consume while full", ex_rdata, xd(3, 0));
        @(posedge clk); #1 ex_valid = 0;
        @(negedge clk); #1;
        check("R8", "reopened", in_ready, 1);
        @(posedge clk); #1 in_valid = 0;
        for (int k = 1; k <= ENT; k++) begin
            ex_send(0, 3, k, '0, rd);
            check("R8", "drain data", rd, xd(3, k));
        end

        // R9: completion waits for the acknowledgment
        clear_caps();
        auto_ack = 0; ack_q.delete(); wack_valid = 0;
        net_send(1, 2, 0, xa(2, 0), '0); ex_send(1, 2, 0, xd(2, 0), rd);
        wait_caps(1);
        done_seen[2] = 0;
        @(negedge clk); end_valid = 1; end_inst = 2;
        @(posedge clk); #1 end_valid = 0;
        repeat (5) @(negedge clk);
        check("R9", "no done before ack", done_seen[2], 0);
        @(negedge clk); wack_valid = 1; wack_inst = 2;
        @(posedge clk); #1 wack_valid = 0;
        check("R9", "done after ack", done_valid, 1);
        check("R9", "done inst", done_inst, 2);
        @(posedge clk); #1;
        check("R9", "one-cycle pulse", done_valid, 0);
        ack_q.delete(); auto_ack = 1;

        // random phase: shuffled halves, random write backpressure
        wr_rand = 1;
        for (int it = 0; it < 30; it++) begin
            int inst, n, ev[10];
            inst = it % 4;
            n = 1 + int'($urandom % 5);
            clear_caps();
            for (int k = 0; k < 2 * n; k++) ev[k] = k;
            for (int k = 2 * n - 1; k > 0; k--) begin
                int j, t;
                j = int'($urandom % (k + 1));
                t = ev[k]; ev[k] = ev[j]; ev[j] = t;
            end
            for (int k = 0; k < 2 * n; k++) begin
                if (ev[k] % 2 == 0) net_send(1, inst, ev[k] / 2, xa(inst, ev[k] / 2 + it), '0);
                else ex_send(1, inst, ev[k] / 2, xd(inst, ev[k] / 2 + it), rd);
            end
            finish_inst(inst, seen);
            check("R9", "random done", seen, 1);
            check("R4", "random count", cap_addr.size(), n);
            for (int k = 0; k < n && k < cap_addr.size(); k++) begin
                check("R6", "random seq", cap_seq[k], k);
                check("R4", "random addr", cap_addr[k], xa(inst, k + it));
                check("R4", "random data", cap_data[k], xd(inst, k + it));
            end
        end
        wr_rand = 0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule